// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides two 32-bit integers over several clock cycles and returns both the quotient and the remainder. It works one quotient bit per cycle. The divisor register moves right past a fixed partial remainder, and the quotient register moves left to take in each new bit. At each step the divisor is subtracted from the partial remainder. If the subtraction borrows, the step keeps the old remainder and records a 0. If it does not borrow, the step keeps the difference and records a 1. A single borrow bit decides this, so the subtractor is only one bit wider than the operands.

Before the first step, the block compares the leading-zero counts of the two operand magnitudes. It shifts the divisor left until its top 1-bit lines up with the top 1-bit of the dividend. As a result, the number of steps is the gap between the two counts plus one, not a fixed 32. When the divisor is wider than the dividend, the result is ready with no steps at all. A zero divisor is flagged and produces no arithmetic result.

A one-cycle `start` loads the operands and the signed/unsigned select. The block raises `busy` and later pulses `done` when the outputs are valid. The outputs hold until the next accepted start.

Top module: `shiftDivider`

## Requirements
- R1: With `signedMode`=0 and a nonzero divisor, the outputs at `done` satisfy quotient*divisor + remainder = dividend and remainder < divisor, all read as unsigned 32-bit values.
- R2: With `signedMode`=1, the operands are two's-complement. The quotient rounds toward zero. The remainder has the sign of the dividend, or is zero. The dividend 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R3: A zero divisor gives `divZero`=1 with quotient 0 and remainder 0. `done` is high in the first cycle after the clock edge that accepts `start`.
- R4: Let lzA and lzB be the leading-zero counts of the dividend and divisor magnitudes, where an all-zero value counts as 32. When the divisor is nonzero and lzB >= lzA, `done` is high exactly lzB-lzA+1 clock edges after the edge that accepts `start`.
- R5: When the divisor is nonzero and lzB < lzA, which includes a zero dividend, `done` is high in the first cycle after the accepting edge. The quotient is 0 and the remainder equals the dividend.
- R6: `busy` rises on the edge that accepts `start` and stays high through the `done` cycle. `done` lasts exactly one cycle, and `busy` is low in the cycle after it.
- R7: A `start` while `busy` is high, including the `done` cycle, is ignored. Its operands never reach the outputs.
- R8: While the block is idle with no `start`, quotient, remainder and `divZero` hold their values, even when `dividend`, `divisor` or `signedMode` change.
- R9: After reset, `busy`, `done` and `divZero` are 0, and quotient and remainder are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division; sampled only while idle |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled with start |
| divisor | input | 32 | Divisor, sampled with start |
| busy | output | 1 | Division in progress (from accept through done) |
| done | output | 1 | One-cycle pulse: outputs valid |
| quotient | output | 32 | Quotient result |
| remainder | output | 32 | Remainder result |
| divZero | output | 1 | Last division had a zero divisor |

## Verification
Two situations are hard to reach from the ports. The first is the extreme step counts: a full 32-step run needs a dividend with its top bit set and a divisor of 1. The second is the boundary where the leading-zero counts are equal, so a single step has to decide between a quotient of 1 and 0. The bench's vector table covers both on purpose. It adds the skip case, the most negative signed dividend and the zero divisor, and checks the count of clock edges to `done` against a leading-zero model of its own. A start raised in the middle of a run, and operand changes while idle, are driven as directed tests, and the bench compares the held results afterwards.

// File: rtl/divPkg.sv
package divPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands and set up the normalized divisor
    logic step;   // perform one restoring subtract/shift step
  } divCtrlT;
endpackage

// File: rtl/lzCount.sv
module lzCount #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [CW-1:0] count
);
  // priority encoder: highest set bit wins, all-zero gives W
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (value[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  divCtrlT       ctrl,
  input  logic          signedMode,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic          zeroDiv,
  output logic          skipRun,
  output logic [CW-1:0] stepCount,
  output logic [W-1:0]  quotient,
  output logic [W-1:0]  remainder,
  output logic          divZero
);
  logic          negA, negB;
  logic [W-1:0]  magA, magB;
  logic [CW-1:0] lzA, lzB, shiftAmt;

  logic [W-1:0]  remReg, quoReg, dvsReg;
  logic          negQ, negR, zeroReg;
  logic [W:0]    diff;
  logic          borrow;

  // operand magnitudes
  assign negA = signedMode & dividend[W-1];
  assign negB = signedMode & divisor[W-1];
  assign magA = negA ? (W'(0) - dividend) : dividend;
  assign magB = negB ? (W'(0) - divisor)  : divisor;

  lzCount #(.W(W)) u_lzA (.value(magA), .count(lzA));
  lzCount #(.W(W)) u_lzB (.value(magB), .count(lzB));

  assign zeroDiv   = (magB == '0);
  assign skipRun   = !zeroDiv && (lzB < lzA);
  assign shiftAmt  = lzB - lzA;
  assign stepCount = shiftAmt + CW'(1);

  // borrow-out of remainder minus divisor decides the bit
  assign diff   = {1'b0, remReg} - {1'b0, dvsReg};
  assign borrow = diff[W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg  <= '0;
      quoReg  <= '0;
      dvsReg  <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
      zeroReg <= 1'b0;
    end else if (ctrl.load) begin
      quoReg  <= '0;
      zeroReg <= zeroDiv;
      if (zeroDiv) begin
        remReg <= '0;
        dvsReg <= '0;
        negQ   <= 1'b0;
        negR   <= 1'b0;
      end else begin
        remReg <= magA;
        dvsReg <= skipRun ? '0 : (magB << shiftAmt);
        negQ   <= negA ^ negB;
        negR   <= negA;
      end
    end else if (ctrl.step) begin
      if (!borrow) remReg <= diff[W-1:0];
      quoReg <= {quoReg[W-2:0], ~borrow};
      dvsReg <= dvsReg >> 1;
    end
  end

  assign quotient  = negQ ? (W'(0) - quoReg) : quoReg;
  assign remainder = negR ? (W'(0) - remReg) : remReg;
  assign divZero   = zeroReg;
endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          zeroDiv,
  input  logic          skipRun,
  input  logic [CW-1:0] stepCount,
  output divCtrlT       ctrl,
  output logic          busy,
  output logic          done
);
  typedef enum logic [1:0] {IDLE, RUN, FIN} stateT;

  stateT         state, stateNext;
  logic [CW-1:0] stepsLeft, stepsNext;

  always_comb begin
    stateNext = state;
    stepsNext = stepsLeft;
    ctrl      = '0;
    unique case (state)
      IDLE: begin
        if (start) begin
          ctrl.load = 1'b1;
          if (zeroDiv || skipRun) begin
            stateNext = FIN;
          end else begin
            stateNext = RUN;
            stepsNext = stepCount;
          end
        end
      end
      RUN: begin
        ctrl.step = 1'b1;
        stepsNext = stepsLeft - CW'(1);
        if (stepsLeft == CW'(1)) stateNext = FIN;
      end
      FIN:     stateNext = IDLE;
      default: stateNext = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= IDLE;
      stepsLeft <= '0;
    end else begin
      state     <= stateNext;
      stepsLeft <= stepsNext;
    end
  end

  assign busy = (state != IDLE);
  assign done = (state == FIN);
endmodule

// File: rtl/shiftDivider.sv
module shiftDivider
  import divPkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         signedMode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         divZero
);
  divCtrlT       ctrl;
  logic          zeroDiv, skipRun;
  logic [CW-1:0] stepCount;

  divControl #(.W(W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .zeroDiv(zeroDiv), .skipRun(skipRun), .stepCount(stepCount),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  divDatapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .signedMode(signedMode), .dividend(dividend), .divisor(divisor),
    .zeroDiv(zeroDiv), .skipRun(skipRun), .stepCount(stepCount),
    .quotient(quotient), .remainder(remainder), .divZero(divZero)
  );
endmodule

// File: rtl/divChecker.sv
module divChecker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         divZero
);
  // R3
  zero_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> (quotient == '0) && (remainder == '0));

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R7
  late_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !busy);

  // R6
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(divZero)));
endmodule

bind shiftDivider divChecker #(.W(W)) u_chk (.*);

// File: tb/shiftDivider_tb.sv
module shiftDivider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, divZero;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shiftDivider u_dut (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .divZero(divZero)
  );

  // vectors: dividend, divisor, signed
  localparam logic [31:0] VA [NVEC] = '{
    32'd100, 32'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5, 32'd0,
    32'd12345678, 32'hFFFF_FFF9, 32'd7, 32'hFFFF_FFF9, 32'hFFFF_FF9C,
    32'h8000_0000, 32'h8000_0000, 32'd3, 32'hFFFF_FFFB, 32'd9
  };
  localparam logic [31:0] VB [NVEC] = '{
    32'd7, 32'd3, 32'd1, 32'hFFFF_FFFF, 32'd9, 32'd5,
    32'h0001_0000, 32'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'd7,
    32'd3, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd12
  };
  localparam logic VS [NVEC] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b1, 1'b0
  };

  function automatic int lzRef(input logic [31:0] v);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return 32;
  endfunction

  task automatic refDiv(input logic [31:0] a, input logic [31:0] b, input logic s,
                        output logic [31:0] q, output logic [31:0] r,
                        output logic z, output int n, output string tag);
    logic [31:0] ma, mb;
    int la, lb;
    ma = (s && a[31]) ? -a : a;
    mb = (s && b[31]) ? -b : b;
    la = lzRef(ma);
    lb = lzRef(mb);
    z = (b == 0);
    if (z) begin
      q = 0; r = 0; n = 0; tag = "R3";
      return;
    end
    n = (lb < la) ? 0 : (lb - la + 1);
    if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = 32'h8000_0000; r = 0;
    end else if (s) begin
      q = 32'($signed(a) / $signed(b));
      r = 32'($signed(a) % $signed(b));
    end else begin
      q = a / b;
      r = a % b;
    end
    tag = (n == 0) ? "R5" : (s ? "R2" : "R1");
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // issue one start and count edges until done; returns edge count
  task automatic runDiv(input logic [31:0] a, input logic [31:0] b, input logic s,
                        output int cycles);
    @(negedge clk);
    dividend = a; divisor = b; signedMode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < 200) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] eq, er;
    logic ez;
    int en, cyc;
    string tag;
    logic [31:0] heldQ, heldR;

    // R9 reset state
    #(CLK_PERIOD * 2 + 1);
    check("R9", "busy", {31'b0, busy}, 32'd0);
    check("R9", "done", {31'b0, done}, 32'd0);
    check("R9", "divZero", {31'b0, divZero}, 32'd0);
    check("R9", "quotient", quotient, 32'd0);
    check("R9", "remainder", remainder, 32'd0);
    rstN = 1'b1;

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      refDiv(VA[i], VB[i], VS[i], eq, er, ez, en, tag);
      runDiv(VA[i], VB[i], VS[i], cyc);
      check(tag, "quotient", quotient, eq);
      check(tag, "remainder", remainder, er);
      check(ez ? "R3" : tag, "divZero", {31'b0, divZero}, {31'b0, ez});
      check(ez ? "R3" : "R4", "edges to done", 32'(cyc), 32'(en));
      // R6 done lasts one cycle, busy drops after it
      @(negedge clk);
      check("R6", "done after pulse", {31'b0, done}, 32'd0);
      check("R6", "busy after pulse", {31'b0, busy}, 32'd0);
    end

    // R7 start while busy is ignored
    @(negedge clk);
    dividend = 32'hFFFF_FFFF; divisor = 32'd1; signedMode = 1'b0; start = 1'b1;
    @(negedge clk);
    dividend = 32'd10; divisor = 32'd3; // second request mid-run
    repeat (3) @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check("R7", "quotient", quotient, 32'hFFFF_FFFF);
    check("R7", "remainder", remainder, 32'd0);
    // start raised during the done cycle
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", "busy after done-cycle start", {31'b0, busy}, 32'd0);
    check("R7", "quotient kept", quotient, 32'hFFFF_FFFF);

    // R8 outputs hold while idle although operands change
    runDiv(32'd50, 32'd6, 1'b0, cyc);
    heldQ = quotient; heldR = remainder;
    check("R8", "quotient result", heldQ, 32'd8);
    dividend = 32'hDEAD_BEEF; divisor = 32'd0; signedMode = 1'b1;
    repeat (5) @(negedge clk);
    check("R8", "quotient held", quotient, 32'd8);
    check("R8", "remainder held", remainder, 32'd2);
    check("R8", "divZero held", {31'b0, divZero}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule